// File: doc/BRIEF.md
# Interrupt Priority Register Bank with Pending Selector

This block stores a 3-bit urgency level for each of 200 interrupt lines. Software programs the levels through a small memory-mapped slave port. There are 50 word registers, and each one carries the levels of four consecutive lines, one level per byte lane. Writes can be narrowed to single byte lanes with strobes. Any access without the privilege flag is refused: a write changes nothing, and a read returns zero together with an error pulse.

Next to the storage sits a purely combinational selector. It scans a 200-bit pending vector and names the most urgent pending line, where a smaller value means more urgent. It also reports that line's group priority. The group priority is the stored level cut at a binary point, and a 3-bit split input places that point inside the byte. Downstream logic can use the result directly for preemption decisions.

Top module: `int_prio_bank`

## Requirements
- R1: Register n (0..49) sits at byte address 0x400 + 4n. The level of line 4n+k (k = 0..3) occupies bits 8k+7 down to 8k+5 of that word.
- R2: All other bits of every register read as zero, and writes to them are discarded.
- R3: After reset every level is 0.
- R4: A privileged write updates only the levels in the byte lanes whose strobe is 1.
- R5: A write with the privilege flag low leaves every level unchanged.
- R6: A read with the privilege flag low returns zero and sets bus_err for that data cycle. In every other cycle bus_err is 0.
- R7: Read data appears on bus_rdata in the cycle after the request, and bus_rdata is zero in any cycle that does not follow a privileged read. A write takes effect at the clock edge of its request, so a read issued in the next cycle already sees it.
- R8: Among the pending lines, the selector reports the one with the lowest level. If several share that level, the lowest line number wins.
- R9: win_valid is 1 exactly when at least one pending bit is set. While it is 0, win_id and win_group are 0.
- R10: win_group is the winner's level with the bits below the binary point cleared. Split values 0 to 4 keep all 3 bits. A split of 5 keeps the upper two bits. A split of 6 keeps the top bit. A split of 7 keeps none.
- R11: Addresses below 0x400, above 0x4C4, or not word aligned read as zero without error, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Privileged access flag |
| bus_rdata | output | 32 | Read data, one cycle after request |
| bus_err | output | 1 | Unprivileged read indication |
| pend | input | 200 | Pending interrupt lines |
| grp_split | input | 3 | Binary point position |
| win_valid | output | 1 | Some line is pending |
| win_id | output | 8 | Winning line number |
| win_group | output | 3 | Winner's group priority |

## Verification
Some behaviours are checked by assertions on every cycle. These are the zero reserved bits in read data, the error pulse and zero data after an unprivileged read, the absence of an error otherwise, and zero read data after non-read cycles. The selector checks cover the agreement between win_valid and the pending vector, a winner that is actually pending, zeroed outputs when idle, and an empty group at split 7. Other behaviours depend on stored history and need the bench's scenarios. Lane placement, strobe masking, refused writes, out-of-window addresses, lowest-value and lowest-number tie-break selection, and the group masks for intermediate split values are all in this group. The bench compares each of them against its own model of the programmed levels.

// File: rtl/int_prio_bank.sv
module int_prio_bank #(
  parameter int NUM_REGS = 50,
  parameter int PRI_W = 3,
  parameter int AW = 12,
  parameter logic [11:0] BASE_ADDR = 12'h400,
  parameter int ID_W = $clog2(NUM_REGS * 4)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [AW-1:0]           bus_addr,
  input  logic [3:0]              bus_be,
  input  logic [31:0]             bus_wdata,
  input  logic                    bus_priv,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  input  logic [NUM_REGS*4-1:0]   pend,
  input  logic [2:0]              grp_split,
  output logic                    win_valid,
  output logic [ID_W-1:0]         win_id,
  output logic [PRI_W-1:0]        win_group
);
  localparam int NUM_IRQ = NUM_REGS * 4;
  localparam int FLD_LSB = 8 - PRI_W;

  logic [PRI_W-1:0] pri [NUM_IRQ];

  logic [AW-3:0] word, word_idx;
  logic          in_range;
  logic [ID_W-1:0] base_id;
  logic [31:0]   rd_word;
  logic          unused_wdata;

  assign word     = bus_addr[AW-1:2] - BASE_ADDR[AW-1:2];
  assign in_range = (bus_addr[1:0] == 2'b00) && (bus_addr >= BASE_ADDR[AW-1:0])
                    && (int'(word) < NUM_REGS);
  assign word_idx = in_range ? word : '0;
  assign base_id  = {word_idx[ID_W-3:0], 2'b00};
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) pri[i] <= '0;
    end else if (bus_sel && bus_we && bus_priv && in_range) begin
      for (int l = 0; l < 4; l++)
        if (bus_be[l]) pri[base_id + ID_W'(l)] <= bus_wdata[8*l+7 -: PRI_W];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int l = 0; l < 4; l++)
      rd_word[8*l+7 -: PRI_W] = in_range ? pri[base_id + ID_W'(l)] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_sel && !bus_we && bus_priv) ? rd_word : '0;
      bus_err   <= bus_sel && !bus_we && !bus_priv;
    end
  end

  logic             found;
  logic [PRI_W-1:0] best_pri;
  logic [ID_W-1:0]  best_id;
  logic [PRI_W-1:0] grp_mask;

  always_comb begin
    found    = 1'b0;
    best_pri = '1;
    best_id  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && (!found || pri[i] < best_pri)) begin
        found    = 1'b1;
        best_pri = pri[i];
        best_id  = ID_W'(i);
      end
    end
  end

  always_comb begin
    for (int j = 0; j < PRI_W; j++)
      grp_mask[j] = (FLD_LSB + j) > int'(grp_split);
  end

  assign win_valid = found;
  assign win_id    = best_id;
  assign win_group = found ? (best_pri & grp_mask) : '0;
endmodule

module int_prio_bank_chk #(
  parameter int NUM_REGS = 50,
  parameter int PRI_W = 3,
  parameter int ID_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_we,
  input logic                  bus_priv,
  input logic [31:0]           bus_rdata,
  input logic                  bus_err,
  input logic [NUM_REGS*4-1:0] pend,
  input logic [2:0]            grp_split,
  input logic                  win_valid,
  input logic [ID_W-1:0]       win_id,
  input logic [PRI_W-1:0]      win_group
);
  localparam logic [31:0] RESV = ~{4{{PRI_W{1'b1}}, {(8-PRI_W){1'b0}}}};

  assert_resv_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & RESV) == 32'h0);

  assert_unpriv_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !bus_priv) |=> (bus_err && bus_rdata == 32'h0));

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we && !bus_priv) |=> !bus_err);

  assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> bus_rdata == 32'h0);

  assert_winner_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (int'(win_id) < NUM_REGS*4 && pend[win_id]));

  assert_valid_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (|pend));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_id == '0 && win_group == '0));

  assert_empty_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_split == 3'd7) |-> win_group == '0);
endmodule

bind int_prio_bank int_prio_bank_chk #(.NUM_REGS(NUM_REGS), .PRI_W(PRI_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/test_int_prio_bank.sv
`timescale 1ns/1ps
module test_int_prio_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_we = 1'b0, bus_priv = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [3:0]   bus_be = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_err;
  logic [199:0] pend = '0;
  logic [2:0]   grp_split = '0;
  logic         win_valid;
  logic [7:0]   win_id;
  logic [2:0]   win_group;

  int checks = 0;
  int fails = 0;
  logic [2:0] mdl [200];

  always #2 clk = ~clk;

  int_prio_bank i_int_prio_bank (.*);

  typedef struct packed {
    logic        we;
    logic        priv;
    logic [11:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,12'h400,4'h0,32'h0,        32'h0,        1'b0,4'd3},  // R3 reset value
    '{1'b1,1'b1,12'h400,4'hF,32'hFFFFFFFF, 32'h0,        1'b0,4'd7},  // R7 write cycle data
    '{1'b0,1'b1,12'h400,4'h0,32'h0,        32'hE0E0E0E0, 1'b0,4'd2},  // R2 reserved cleared
    '{1'b1,1'b1,12'h404,4'h5,32'hFFFFFFFF, 32'h0,        1'b0,4'd4},
    '{1'b0,1'b1,12'h404,4'h0,32'h0,        32'h00E000E0, 1'b0,4'd4},  // R4 lanes 0 and 2
    '{1'b1,1'b0,12'h404,4'hF,32'h0,        32'h0,        1'b0,4'd5},
    '{1'b0,1'b1,12'h404,4'h0,32'h0,        32'h00E000E0, 1'b0,4'd5},  // R5 unchanged
    '{1'b0,1'b0,12'h400,4'h0,32'h0,        32'h0,        1'b1,4'd6},  // R6 refused read
    '{1'b1,1'b1,12'h4C4,4'hF,32'h60A0C020, 32'h0,        1'b0,4'd1},
    '{1'b0,1'b1,12'h4C4,4'h0,32'h0,        32'h60A0C020, 1'b0,4'd1},  // R1 last register
    '{1'b0,1'b1,12'h3FC,4'h0,32'h0,        32'h0,        1'b0,4'd11}, // R11 below window
    '{1'b1,1'b1,12'h4C8,4'hF,32'hFFFFFFFF, 32'h0,        1'b0,4'd11},
    '{1'b0,1'b1,12'h4C8,4'h0,32'h0,        32'h0,        1'b0,4'd11}, // R11 above window
    '{1'b1,1'b1,12'h402,4'hF,32'h0,        32'h0,        1'b0,4'd11},
    '{1'b0,1'b1,12'h400,4'h0,32'h0,        32'hE0E0E0E0, 1'b0,4'd11}, // R11 misaligned ignored
    '{1'b1,1'b1,12'h408,4'h2,32'hFFFF40FF, 32'h0,        1'b0,4'd4},
    '{1'b0,1'b1,12'h408,4'h0,32'h0,        32'h00004000, 1'b0,4'd1}   // R1 lane 1 placement
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic priv, input logic [11:0] addr,
                     input logic [3:0] be, input logic [31:0] wd,
                     input logic [31:0] exp, input logic err, input int req);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_priv = priv;
    bus_addr = addr; bus_be = be; bus_wdata = wd;
    if (we && priv && addr[1:0] == 2'b00 && addr >= 12'h400 && addr <= 12'h4C4)
      for (int l = 0; l < 4; l++)
        if (be[l]) mdl[(int'(addr - 12'h400) >> 2) * 4 + l] = wd[8*l+5 +: 3];
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    check(req, bus_rdata, exp);
    check(req, {31'b0, bus_err}, {31'b0, err});
  endtask

  function automatic logic [11:0] model_sel(input logic [199:0] p, input logic [2:0] g);
    logic v = 1'b0;
    logic [2:0] bp = '0;
    logic [7:0] bi = '0;
    logic [2:0] m;
    for (int i = 0; i < 200; i++)
      if (p[i] && (!v || mdl[i] < bp)) begin v = 1'b1; bp = mdl[i]; bi = 8'(i); end
    m = (g == 3'd7) ? 3'b000 : (g == 3'd6) ? 3'b100 : (g == 3'd5) ? 3'b110 : 3'b111;
    return {v, bi, v ? (bp & m) : 3'b000};
  endfunction

  task automatic sel_check(input logic [199:0] p, input logic [2:0] g, input int req);
    @(negedge clk);
    pend = p; grp_split = g;
    #1;
    check(req, {20'b0, win_valid, win_id, win_group}, {20'b0, model_sel(p, g)});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [199:0] p;
    for (int i = 0; i < 200; i++) mdl[i] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(3, {win_valid, bus_rdata}, 33'h0);  // R3 outputs after reset

    for (int v = 0; v < NV; v++)
      bus(VECS[v].we, VECS[v].priv, VECS[v].addr, VECS[v].be, VECS[v].wd,
          VECS[v].exp, VECS[v].err, int'(VECS[v].req));

    bus(1'b1, 1'b1, 12'h40C, 4'hF, 32'h20204060, 32'h0, 1'b0, 7);
    bus(1'b0, 1'b1, 12'h40C, 4'h0, 32'h0, 32'h20204060, 1'b0, 7);  // R7 immediate read-back

    sel_check('0, 3'd0, 9);                                // R9 nothing pending
    p = '0; p[0] = 1'b1; p[199] = 1'b1;
    sel_check(p, 3'd0, 8);                                 // R8 level 7 vs 3
    p = '0; p[0] = 1'b1; p[1] = 1'b1;
    sel_check(p, 3'd0, 8);                                 // R8 tie, lowest number
    p = '0; p[14] = 1'b1; p[13] = 1'b1; p[15] = 1'b1;
    sel_check(p, 3'd0, 8);                                 // R8 tie at level 1
    p = '0; p[5] = 1'b1; p[196] = 1'b1;
    sel_check(p, 3'd0, 8);                                 // R8 level 0 wins
    sel_check('1, 3'd2, 8);                                // R8 all pending
    for (int g = 0; g < 8; g++) begin
      p = '0; p[198] = 1'b1;
      sel_check(p, 3'(g), 10);                             // R10 level 5 masks
      p = '0; p[199] = 1'b1;
      sel_check(p, 3'(g), 10);                             // R10 level 3 masks
    end
    @(negedge clk);
    pend = '0; grp_split = '0;

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) mdl[i] = 3'd0;
    bus(1'b0, 1'b1, 12'h4C4, 4'h0, 32'h0, 32'h0, 1'b0, 3);  // R3 cleared by reset
    p = '0; p[199] = 1'b1; p[3] = 1'b1;
    sel_check(p, 3'd0, 3);                                  // R3 all levels zero
    summary();
  end
endmodule